// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block sequences a small microcontroller into and out of its low-power modes. The CPU pulses a stop strobe or a wait strobe. The controller then decides which clocks to gate, whether the oscillator keeps running and whether counters freeze. It also decides which events are allowed to bring the system back to run.

A stop request that arrives while the nonvolatile memory controller reports a command in flight is not taken at once. The clocks keep running until the busy flag drops. If an interrupt shows up during that wait, the stop is abandoned.

Two stop depths are available, chosen by a select bit at the moment the strobe is taken:
- **Shallow stop** keeps the oscillator alive and accepts four timer and converter wake sources.
- **Deep stop** shuts the oscillator down, freezes counters and accepts only two self-wake sources. On leaving deep stop, the controller either restarts at once on the internal PLL clock or waits for the oscillator to report ready.

Top module: `lpm_ctrl`

## Requirements
- R1: While `rst` is high, the outputs read run in that same cycle, without waiting for a clock edge: `cpu_clk_en`=1, `per_clk_en`=1, `osc_en`=1, `cnt_freeze`=0, `wake_clk_sel`=0, `mode_code`=2'b00. After reset is released the block stays in run.
- R2: A `stop_strobe` taken in run with `nvm_busy` low moves the block to a stop mode on the next clock. The depth comes from `pseudo_sel` in the strobe cycle: 1 gives shallow stop (`mode_code`=2'b10) and 0 gives deep stop (`mode_code`=2'b11). Stop has priority over a simultaneous `wait_strobe`.
- R3: A `stop_strobe` taken while `nvm_busy` is high keeps all clocks running with `mode_code`=2'b00. The stop mode chosen at the strobe is entered one clock after `nvm_busy` is seen low.
- R4: During a deferred stop, an interrupt (`nmi_req`, `ext_irq`, or a bit of `irq_req` whose `irq_en` bit is 1) cancels the stop. The block stays in run, and the later fall of `nvm_busy` no longer causes a stop.
- R5: In deep stop, `osc_en`=0, `cpu_clk_en`=0, `per_clk_en`=0 and `cnt_freeze`=1.
- R6: In deep stop, the only self-wake sources are `pit_wake_req` gated by `pit_wake_en` and `adc_wake_req` gated by `adc_wake_en`. Requests from the real-time and watchdog timers have no effect.
- R7: On a deep-stop wake with `fast_wake_en`=1, the block returns to run on the next clock with `wake_clk_sel`=1. With `fast_wake_en`=0, it keeps `mode_code`=2'b11 and clocks gated but raises `osc_en`, and it returns to run one clock after `osc_ready` is seen high, with `wake_clk_sel`=0.
- R8: In shallow stop, `osc_en`=1, `cpu_clk_en`=0, `per_clk_en`=0 and `cnt_freeze`=0. Any of the four timer and converter requests, each gated by its own enable, returns the block to run on the next clock.
- R9: A `wait_strobe` taken in run gives `mode_code`=2'b01 on the next clock, with `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1.
- R10: `nmi_req`, `ext_irq`, or an `irq_req` bit whose `irq_en` bit is 1 ends wait and both stop modes one clock after it is seen. An `irq_req` bit whose enable is 0 has no effect.
- R11: A stop or wait strobe that arrives while the block is in wait, in either stop mode, waiting for the oscillator, or deferring a stop is ignored.
- R12: Once set, `wake_clk_sel` stays high in run until `osc_ready` is seen high, and then it clears on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; also forces run outputs immediately |
| stop_strobe | input | 1 | CPU stop instruction pulse |
| wait_strobe | input | 1 | CPU wait instruction pulse |
| nvm_busy | input | 1 | Nonvolatile memory command in progress |
| pseudo_sel | input | 1 | 1 selects shallow stop, 0 deep stop |
| fast_wake_en | input | 1 | Deep-stop exit on internal PLL clock without oscillator wait |
| osc_ready | input | 1 | Oscillator stable indication |
| nmi_req | input | 1 | Non-maskable interrupt |
| ext_irq | input | 1 | External interrupt pin request |
| irq_req | input | IRQ_W | Peripheral interrupt requests |
| irq_en | input | IRQ_W | Per-request enable; 1 means unmasked |
| rti_wake_req | input | 1 | Real-time timer wake request |
| rti_wake_en | input | 1 | Real-time timer wake enable |
| cop_wake_req | input | 1 | Watchdog wake request |
| cop_wake_en | input | 1 | Watchdog wake enable |
| pit_wake_req | input | 1 | Periodic-interrupt timer wake request |
| pit_wake_en | input | 1 | Periodic-interrupt timer wake enable |
| adc_wake_req | input | 1 | ADC wake request |
| adc_wake_en | input | 1 | ADC wake enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| osc_en | output | 1 | Oscillator enable |
| cnt_freeze | output | 1 | Freeze counters and dividers |
| wake_clk_sel | output | 1 | 1 = running on internal PLL clock after fast wake |
| mode_code | output | 2 | 00 run, 01 wait, 10 shallow stop, 11 deep stop |

## Verification
The bench aims at the deferral window. Its checks detect two faults:
- a controller that ignores `nvm_busy`, which would gate the clocks while memory is still busy;
- a controller that forgets the cancel, which would drop into stop after an interrupt was already seen.

It checks that wake sources are filtered per depth, since a design that merges the two lists would wake from deep stop on a real-time or watchdog request. It checks that masked interrupts leave the block asleep. It also covers both deep-stop exit paths: a design that skips the oscillator wait would return to run while `osc_ready` is still low.

Finally, it drives reset in the middle of deep stop and checks that the clocks are enabled before the next edge, and that strobes sent during a low-power mode do not change its state.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_DEFER   = 3'd1,
        ST_WAIT    = 3'd2,
        ST_PSTOP   = 3'd3,
        ST_FSTOP   = 3'd4,
        ST_OSCWAIT = 3'd5
    } lp_state_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic freeze;
    } gate_t;

    typedef struct packed {
        logic irq;         // any interrupt that ends wait
        logic pstop_wake;  // interrupt or shallow-stop self wake
        logic fstop_wake;  // interrupt or deep-stop self wake
    } wake_t;

    localparam logic [1:0] MC_RUN   = 2'b00;
    localparam logic [1:0] MC_WAIT  = 2'b01;
    localparam logic [1:0] MC_PSTOP = 2'b10;
    localparam logic [1:0] MC_FSTOP = 2'b11;

    localparam gate_t GATE_RUN = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, freeze: 1'b0};

    function automatic gate_t gates_of(lp_state_t s);
        gate_t g;
        case (s)
            ST_WAIT:    g = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, freeze: 1'b0};
            ST_PSTOP:   g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, freeze: 1'b0};
            ST_FSTOP:   g = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, freeze: 1'b1};
            ST_OSCWAIT: g = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, freeze: 1'b1};
            default:    g = GATE_RUN;
        endcase
        return g;
    endfunction

    function automatic logic [1:0] code_of(lp_state_t s);
        logic [1:0] c;
        case (s)
            ST_WAIT:              c = MC_WAIT;
            ST_PSTOP:             c = MC_PSTOP;
            ST_FSTOP, ST_OSCWAIT: c = MC_FSTOP;
            default:              c = MC_RUN;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lpm_wake_eval.sv
module lpm_wake_eval
    import lpm_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             nmi_req,
    input  logic             ext_irq,
    input  logic [IRQ_W-1:0] irq_req,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             rti_wake_req,
    input  logic             rti_wake_en,
    input  logic             cop_wake_req,
    input  logic             cop_wake_en,
    input  logic             pit_wake_req,
    input  logic             pit_wake_en,
    input  logic             adc_wake_req,
    input  logic             adc_wake_en,
    output wake_t            wake
);
    localparam int NSRC = 4;

    logic [IRQ_W-1:0] live_irq;
    logic [NSRC-1:0]  src_req;
    logic [NSRC-1:0]  src_en;
    logic [NSRC-1:0]  src_hit;
    logic             any_irq;

    assign src_req = {adc_wake_req, pit_wake_req, cop_wake_req, rti_wake_req};
    assign src_en  = {adc_wake_en,  pit_wake_en,  cop_wake_en,  rti_wake_en};

    for (genvar i = 0; i < IRQ_W; i++) begin : g_irq
        assign live_irq[i] = irq_req[i] & irq_en[i];
    end

    for (genvar j = 0; j < NSRC; j++) begin : g_src
        assign src_hit[j] = src_req[j] & src_en[j];
    end

    assign any_irq         = nmi_req | ext_irq | (|live_irq);
    assign wake.irq        = any_irq;
    assign wake.pstop_wake = any_irq | (|src_hit);
    // bits 2 and 3 are the periodic timer and the converter
    assign wake.fstop_wake = any_irq | src_hit[2] | src_hit[3];

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      stop_strobe,
    input  logic      wait_strobe,
    input  logic      nvm_busy,
    input  logic      pseudo_sel,
    input  logic      fast_wake_en,
    input  logic      osc_ready,
    input  wake_t     wake,
    output lp_state_t state,
    output logic      pll_sel
);
    lp_state_t nxt;
    logic      deep_q, deep_nxt;
    logic      pll_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_RUN;
            deep_q  <= 1'b0;
            pll_sel <= 1'b0;
        end else begin
            state   <= nxt;
            deep_q  <= deep_nxt;
            pll_sel <= pll_nxt;
        end
    end

    always_comb begin
        nxt      = state;
        deep_nxt = deep_q;
        pll_nxt  = pll_sel;
        case (state)
            ST_RUN: begin
                if (pll_sel && osc_ready) pll_nxt = 1'b0;
                if (stop_strobe) begin
                    deep_nxt = ~pseudo_sel;
                    if (nvm_busy)        nxt = ST_DEFER;
                    else if (pseudo_sel) nxt = ST_PSTOP;
                    else                 nxt = ST_FSTOP;
                end else if (wait_strobe) begin
                    nxt = ST_WAIT;
                end
            end
            ST_DEFER: begin
                if (wake.irq)       nxt = ST_RUN;
                else if (!nvm_busy) nxt = deep_q ? ST_FSTOP : ST_PSTOP;
            end
            ST_WAIT: begin
                if (wake.irq) nxt = ST_RUN;
            end
            ST_PSTOP: begin
                if (wake.pstop_wake) nxt = ST_RUN;
            end
            ST_FSTOP: begin
                if (wake.fstop_wake) begin
                    if (fast_wake_en) begin
                        nxt     = ST_RUN;
                        pll_nxt = 1'b1;
                    end else begin
                        nxt = ST_OSCWAIT;
                    end
                end
            end
            ST_OSCWAIT: begin
                if (osc_ready) nxt = ST_RUN;
            end
            default: nxt = ST_RUN;
        endcase
    end

endmodule

// File: rtl/lpm_out.sv
module lpm_out
    import lpm_pkg::*;
(
    input  lp_state_t  state,
    input  logic       pll_sel,
    input  logic       rst,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       osc_en,
    output logic       cnt_freeze,
    output logic       wake_clk_sel,
    output logic [1:0] mode_code
);
    gate_t g;

    always_comb begin
        g = rst ? GATE_RUN : gates_of(state);
    end

    assign cpu_clk_en   = g.cpu;
    assign per_clk_en   = g.per;
    assign osc_en       = g.osc;
    assign cnt_freeze   = g.freeze;
    assign wake_clk_sel = pll_sel & ~rst;
    assign mode_code    = rst ? MC_RUN : code_of(state);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int IRQ_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stop_strobe,
    input  logic             wait_strobe,
    input  logic             nvm_busy,
    input  logic             pseudo_sel,
    input  logic             fast_wake_en,
    input  logic             osc_ready,
    input  logic             nmi_req,
    input  logic             ext_irq,
    input  logic [IRQ_W-1:0] irq_req,
    input  logic [IRQ_W-1:0] irq_en,
    input  logic             rti_wake_req,
    input  logic             rti_wake_en,
    input  logic             cop_wake_req,
    input  logic             cop_wake_en,
    input  logic             pit_wake_req,
    input  logic             pit_wake_en,
    input  logic             adc_wake_req,
    input  logic             adc_wake_en,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             cnt_freeze,
    output logic             wake_clk_sel,
    output logic [1:0]       mode_code
);
    wake_t     wake;
    lp_state_t state;
    logic      pll_sel;

    lpm_wake_eval #(.IRQ_W(IRQ_W)) i_wake (
        .nmi_req      (nmi_req),
        .ext_irq      (ext_irq),
        .irq_req      (irq_req),
        .irq_en       (irq_en),
        .rti_wake_req (rti_wake_req),
        .rti_wake_en  (rti_wake_en),
        .cop_wake_req (cop_wake_req),
        .cop_wake_en  (cop_wake_en),
        .pit_wake_req (pit_wake_req),
        .pit_wake_en  (pit_wake_en),
        .adc_wake_req (adc_wake_req),
        .adc_wake_en  (adc_wake_en),
        .wake         (wake)
    );

    lpm_seq i_seq (
        .clk          (clk),
        .rst          (rst),
        .stop_strobe  (stop_strobe),
        .wait_strobe  (wait_strobe),
        .nvm_busy     (nvm_busy),
        .pseudo_sel   (pseudo_sel),
        .fast_wake_en (fast_wake_en),
        .osc_ready    (osc_ready),
        .wake         (wake),
        .state        (state),
        .pll_sel      (pll_sel)
    );

    lpm_out i_out (
        .state        (state),
        .pll_sel      (pll_sel),
        .rst          (rst),
        .cpu_clk_en   (cpu_clk_en),
        .per_clk_en   (per_clk_en),
        .osc_en       (osc_en),
        .cnt_freeze   (cnt_freeze),
        .wake_clk_sel (wake_clk_sel),
        .mode_code    (mode_code)
    );

endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       nvm_busy,
    input logic       nmi_req,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       cnt_freeze,
    input logic [1:0] mode_code
);
    // R1
    rst_run_chk: assert property (@(posedge clk)
        rst |-> (cpu_clk_en && per_clk_en && osc_en && !cnt_freeze && mode_code == 2'b00));

    // R3
    busy_no_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 2'b00 && nvm_busy) |=> !mode_code[1]);

    // R5
    fstop_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 2'b11) |-> (!cpu_clk_en && !per_clk_en && cnt_freeze));

    // R8
    pstop_osc_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 2'b10) |-> (osc_en && !per_clk_en && !cpu_clk_en && !cnt_freeze));

    // R9
    wait_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 2'b01) |-> (!cpu_clk_en && per_clk_en && osc_en));

    // R10
    nmi_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_code == 2'b01 && nmi_req) |=> (mode_code == 2'b00));

endmodule

bind lpm_ctrl lpm_ctrl_chk i_lpm_ctrl_chk (
    .clk        (clk),
    .rst        (rst),
    .nvm_busy   (nvm_busy),
    .nmi_req    (nmi_req),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .osc_en     (osc_en),
    .cnt_freeze (cnt_freeze),
    .mode_code  (mode_code)
);

// File: tb/test_lpm_ctrl.sv
module test_lpm_ctrl;
    localparam int IRQ_W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_strobe = 0, wait_strobe = 0, nvm_busy = 0, pseudo_sel = 0;
    logic fast_wake_en = 0, osc_ready = 0, nmi_req = 0, ext_irq = 0;
    logic [IRQ_W-1:0] irq_req = '0, irq_en = '0;
    logic rti_wake_req = 0, rti_wake_en = 0, cop_wake_req = 0, cop_wake_en = 0;
    logic pit_wake_req = 0, pit_wake_en = 0, adc_wake_req = 0, adc_wake_en = 0;
    logic cpu_clk_en, per_clk_en, osc_en, cnt_freeze, wake_clk_sel;
    logic [1:0] mode_code;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // model state: 0 run, 1 defer, 2 wait, 3 shallow, 4 deep, 5 osc wait
    int m_st = 0;
    bit m_deep = 0, m_pll = 0;

    always #10 clk = ~clk;

    lpm_ctrl #(.IRQ_W(IRQ_W)) i_lpm_ctrl (.*);

    function automatic logic [6:0] exp_out(int st, bit pll, bit r);
        // {wake_clk_sel, cnt_freeze, osc_en, per_clk_en, cpu_clk_en, mode_code}
        if (r) return 7'b0011100;
        case (st)
            2:       return {pll, 6'b011001};
            3:       return {pll, 6'b010010};
            4:       return {pll, 6'b100011};
            5:       return {pll, 6'b110011};
            default: return {pll, 6'b011100};
        endcase
    endfunction

    function automatic logic [6:0] act_out();
        return {wake_clk_sel, cnt_freeze, osc_en, per_clk_en, cpu_clk_en, mode_code};
    endfunction

    task automatic model_step();
        bit irq, ps_w, fs_w;
        irq  = nmi_req | ext_irq | (|(irq_req & irq_en));
        ps_w = irq | (rti_wake_req & rti_wake_en) | (cop_wake_req & cop_wake_en)
                   | (pit_wake_req & pit_wake_en) | (adc_wake_req & adc_wake_en);
        fs_w = irq | (pit_wake_req & pit_wake_en) | (adc_wake_req & adc_wake_en);
        if (rst) begin
            m_st = 0; m_deep = 0; m_pll = 0;
            return;
        end
        case (m_st)
            0: begin
                if (m_pll && osc_ready) m_pll = 0;
                if (stop_strobe) begin
                    m_deep = !pseudo_sel;
                    m_st = nvm_busy ? 1 : (pseudo_sel ? 3 : 4);
                end else if (wait_strobe) m_st = 2;
            end
            1: if (irq) m_st = 0; else if (!nvm_busy) m_st = m_deep ? 4 : 3;
            2: if (irq) m_st = 0;
            3: if (ps_w) m_st = 0;
            4: if (fs_w) begin
                   if (fast_wake_en) begin m_st = 0; m_pll = 1; end
                   else m_st = 5;
               end
            5: if (osc_ready) m_st = 0;
            default: m_st = 0;
        endcase
    endtask

    task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: inputs were driven at the preceding negedge
    task automatic cyc(string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(tag, act_out(), exp_out(m_st, m_pll, rst));
    endtask

    task automatic pulse_stop(bit ps, string tag);
        pseudo_sel = ps; stop_strobe = 1;
        cyc(tag);
        stop_strobe = 0;
    endtask

    task automatic clear_wakes();
        nmi_req = 0; ext_irq = 0; irq_req = '0;
        rti_wake_req = 0; cop_wake_req = 0; pit_wake_req = 0; adc_wake_req = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog R1: actual hung expected finish");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        chk("R1 reset", act_out(), 7'b0011100);
        cyc("R1 reset");
        rst = 0;
        cyc("R1 after reset");
        chk("R1 run code", {5'b0, mode_code}, 7'b0);

        // R2 shallow stop, R8 outputs and wake
        pulse_stop(1, "R2 shallow entry");
        chk("R8 shallow gates", act_out(), 7'b0010010);
        pit_wake_en = 0; pit_wake_req = 1;
        cyc("R8 disabled source ignored");
        chk("R8 stays", {5'b0, mode_code}, 7'b0000010);
        pit_wake_req = 0; rti_wake_en = 1; rti_wake_req = 1;
        cyc("R8 rti wake");
        chk("R8 run", {5'b0, mode_code}, 7'b0);
        clear_wakes();

        // R5 deep stop, R6 filter, R7 fast wake, R12
        fast_wake_en = 1; cop_wake_en = 1;
        pulse_stop(0, "R2 deep entry");
        chk("R5 deep gates", act_out(), 7'b0100011);
        rti_wake_req = 1; cop_wake_req = 1;
        cyc("R6 rti cop ignored");
        chk("R6 stays deep", {5'b0, mode_code}, 7'b0000011);
        rti_wake_req = 0; cop_wake_req = 0;
        pit_wake_en = 1; pit_wake_req = 1;
        cyc("R7 fast wake");
        chk("R7 fast run sel", act_out(), 7'b1011100);
        pit_wake_req = 0;
        cyc("R12 holds");
        chk("R12 sel held", {6'b0, wake_clk_sel}, 7'b1);
        osc_ready = 1;
        cyc("R12 clears");
        chk("R12 sel cleared", {6'b0, wake_clk_sel}, 7'b0);
        osc_ready = 0;

        // R7 slow wake through oscillator wait
        fast_wake_en = 0; adc_wake_en = 1;
        pulse_stop(0, "R2 deep entry 2");
        adc_wake_req = 1;
        cyc("R7 slow wake");
        chk("R7 osc wait", act_out(), 7'b0110011);
        adc_wake_req = 0;
        cyc("R7 still waiting");
        osc_ready = 1;
        cyc("R7 osc ready");
        chk("R7 run no pll", act_out(), 7'b0011100);
        osc_ready = 0;

        // R3 deferral and R11 during deferral
        nvm_busy = 1;
        pulse_stop(0, "R3 deferred");
        chk("R3 clocks on", act_out(), 7'b0011100);
        pulse_stop(1, "R11 strobe in defer");
        cyc("R3 still busy");
        nvm_busy = 0;
        cyc("R3 enters stop");
        chk("R3 deep chosen", {5'b0, mode_code}, 7'b0000011);
        nmi_req = 1;
        cyc("R10 nmi exit deep");
        nmi_req = 0; osc_ready = 1;
        cyc("R10 osc");
        osc_ready = 0;

        // R4 cancel during deferral
        nvm_busy = 1;
        pulse_stop(1, "R4 deferred");
        ext_irq = 1;
        cyc("R4 cancel");
        ext_irq = 0; nvm_busy = 0;
        cyc("R4 no stop after cancel");
        chk("R4 run", {5'b0, mode_code}, 7'b0);

        // R9 wait, R11 ignored strobe, R10 masking
        wait_strobe = 1;
        cyc("R9 wait entry");
        wait_strobe = 0;
        chk("R9 gates", act_out(), 7'b0011001);
        pulse_stop(0, "R11 stop in wait");
        chk("R11 still wait", {5'b0, mode_code}, 7'b0000001);
        irq_req = 8'h10; irq_en = 8'hEF;
        cyc("R10 masked ignored");
        chk("R10 masked stays", {5'b0, mode_code}, 7'b0000001);
        irq_en = 8'h10;
        cyc("R10 unmasked exit");
        chk("R10 run", {5'b0, mode_code}, 7'b0);
        clear_wakes(); irq_en = '0;

        // R1 reset mid deep stop: immediate
        pulse_stop(0, "R2 deep entry 3");
        rst = 1;
        #1;
        chk("R1 immediate", act_out(), 7'b0011100);
        cyc("R1 reset held");
        rst = 0;
        cyc("R1 released");

        // constrained random against the model
        for (int k = 0; k < 4000; k++) begin
            stop_strobe  = ($urandom % 8) == 0;
            wait_strobe  = ($urandom % 8) == 0;
            pseudo_sel   = $urandom % 2;
            fast_wake_en = $urandom % 2;
            if (($urandom % 6) == 0) nvm_busy = ~nvm_busy;
            osc_ready    = ($urandom % 4) == 0;
            nmi_req      = ($urandom % 40) == 0;
            ext_irq      = ($urandom % 30) == 0;
            irq_req      = (($urandom % 5) == 0) ? IRQ_W'($urandom) : '0;
            irq_en       = IRQ_W'($urandom) & IRQ_W'($urandom);
            rti_wake_req = ($urandom % 10) == 0;  rti_wake_en = $urandom % 2;
            cop_wake_req = ($urandom % 10) == 0;  cop_wake_en = $urandom % 2;
            pit_wake_req = ($urandom % 10) == 0;  pit_wake_en = $urandom % 2;
            adc_wake_req = ($urandom % 10) == 0;  adc_wake_en = $urandom % 2;
            rst          = ($urandom % 500) == 0;
            cyc("R11 random model");
        end
        summary();
    end
endmodule